// File: doc/BRIEF.md
# Privilege-Stack Trap Controller

This block sits beside a core's pipeline and owns the privilege state that traps and trap returns manipulate. It keeps a three-level stack: the current privilege and interrupt enable, plus two saved levels below it, and a modify-privilege flag. Each cycle it looks at the pending and enable interrupt vectors, a host-message word, a synchronous exception request and a trap-return request. It decides whether a trap is taken, and then pushes or pops the stack in one clock edge.

A trap produces a one-cycle redirect. The target is a fixed vector base plus 0x40 times the privilege held before the push. On the same cycle the cause register and a reservation-clear pulse become valid. A trap return pops the stack and refills the bottom level with user privilege and an enable of 1. A status load port lets the surrounding status-register datapath write the stack fields. Privilege values other than user, supervisor or machine are refused field by field.

The sequencer has four states. ST_BOOT is the reset state and presents the reset redirect. ST_IDLE means no event in the previous cycle. ST_ENTRY presents a trap's redirect and reservation clear. ST_EXIT presents the return-done pulse. From any state, the transition on an edge depends only on the event decided in that cycle:
- a trap goes to ST_ENTRY;
- a return goes to ST_EXIT;
- a load or no event goes to ST_IDLE.

Top module: `priv_trap_unit`

## Requirements
- R1: While reset is held, the outputs are as follows. Current privilege is machine (encoding user=0, supervisor=1, machine=3). Both stacked privileges are user. All enables and the modify-privilege flag are 0 and the cause is 0. The redirect is valid with address VEC_BASE+0x100, and the reservation-clear and return-done pulses are low.
- R2: A trap updates the stack on its edge. Level 2 takes the level-1 privilege and enable, and level 1 takes the current ones. The current privilege becomes machine, the current enable becomes 0, and the modify-privilege flag becomes 0.
- R3: A trap return updates the stack on its edge. The current privilege and enable take the level-1 values, and level 1 takes the level-2 values. Level 2 is refilled with user privilege and enable 1. In the following cycle ret_done_o is high for one cycle.
- R4: In the cycle after a trap's edge, redirect_vld_o and resv_clr_o are high for one cycle. In that cycle redirect_pc_o equals VEC_BASE + 0x40 × (the privilege held before the trap). redirect_pc_o holds its value otherwise.
- R5: Machine-level interrupts (machine software, machine timer, host message) are taken only when the current privilege is below machine, or is machine with the current enable set.
- R6: Supervisor interrupts (supervisor software, supervisor timer) are taken only when the current privilege is user, or is supervisor with the current enable set.
- R7: Interrupt vector bits are as follows: bit 0 supervisor software, bit 1 machine software, bit 2 supervisor timer, bit 3 machine timer. A source is live only when both its pending bit and its enable bit are set; the host message is live whenever its word is nonzero. The priority order is machine software, machine timer, host, supervisor software, supervisor timer.
- R8: For an interrupt, the cause has its top bit set, and the low bits carry 0 for software, 1 for timer and 2 for host. For an exception, the cause has its top bit clear and the low bits carry the exception code.
- R9: At most one event is accepted per cycle, in this order: exception, interrupt, return, status load. A return or load that loses to a trap has no effect on the stack.
- R10: A status load writes each enable and the modify-privilege flag directly. It writes each privilege field only if the loaded value is not 2; otherwise that field keeps its value. The value 2 never appears on any privilege output.
- R11: When no event is accepted, the stack, cause and redirect address are unchanged and no pulse is raised. The reservation-clear and return-done pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend_i | input | 4 | Pending interrupt bits (layout in R7) |
| irq_en_i | input | 4 | Interrupt enable bits, same layout |
| host_msg_i | input | HOST_W | Host message word; nonzero requests an interrupt |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | ECODE_W | Exception code |
| ret_req_i | input | 1 | Trap-return request |
| st_ld_i | input | 1 | Status load strobe |
| st_ld_prv_i | input | 2 | Loaded current privilege |
| st_ld_ie_i | input | 1 | Loaded current enable |
| st_ld_prv1_i | input | 2 | Loaded level-1 privilege |
| st_ld_ie1_i | input | 1 | Loaded level-1 enable |
| st_ld_prv2_i | input | 2 | Loaded level-2 privilege |
| st_ld_ie2_i | input | 1 | Loaded level-2 enable |
| st_ld_mprv_i | input | 1 | Loaded modify-privilege flag |
| prv_o | output | 2 | Current privilege |
| ie_o | output | 1 | Current interrupt enable |
| prv1_o | output | 2 | Level-1 privilege |
| ie1_o | output | 1 | Level-1 enable |
| prv2_o | output | 2 | Level-2 privilege |
| ie2_o | output | 1 | Level-2 enable |
| mprv_o | output | 1 | Modify-privilege flag |
| cause_o | output | XLEN | Cause of the latest trap |
| redirect_vld_o | output | 1 | Redirect valid (reset or trap) |
| redirect_pc_o | output | XLEN | Redirect address |
| resv_clr_o | output | 1 | Load-reservation clear pulse |
| ret_done_o | output | 1 | Trap-return completed pulse |

## Verification
An exception and a live interrupt can arrive in the same cycle. The bench forces this by raising exc_req_i while every interrupt source is pending and enabled. It then checks that the cause carries a clear top bit and the exception code. A return or a status load can also coincide with a trap. The bench drives ret_req_i together with a live interrupt, and ret_req_i together with st_ld_i. A reference model computes the expected result, so a return that slips past a trap, or a load that survives a pop, shows up as a stack or pulse miscompare.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [1:0] {
        PL_USER  = 2'd0,
        PL_SUPER = 2'd1,
        PL_RSVD  = 2'd2,
        PL_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ENTRY = 2'd2,
        ST_EXIT  = 2'd3
    } fsm_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TRAP = 2'd1,
        EV_RET  = 2'd2,
        EV_LOAD = 2'd3
    } event_e;

    typedef struct packed {
        logic [1:0] prv;
        logic       ie;
        logic [1:0] prv1;
        logic       ie1;
        logic [1:0] prv2;
        logic       ie2;
        logic       mprv;
    } pstack_t;

    localparam int IRQ_NUM  = 4;
    localparam int IRQ_S_SW = 0;
    localparam int IRQ_M_SW = 1;
    localparam int IRQ_S_TM = 2;
    localparam int IRQ_M_TM = 3;

    localparam logic [1:0] CODE_SW   = 2'd0;
    localparam logic [1:0] CODE_TM   = 2'd1;
    localparam logic [1:0] CODE_HOST = 2'd2;

    localparam int VEC_SHIFT = 6;
    localparam int BOOT_OFS  = 256;

    function automatic logic priv_ok(input logic [1:0] p);
        return p != PL_RSVD;
    endfunction

endpackage

// File: rtl/ptc_irq_arb.sv
module ptc_irq_arb
    import ptc_pkg::*;
#(
    parameter int HOST_W = 8
) (
    input  logic [1:0]         cur_prv,
    input  logic               cur_ie,
    input  logic [IRQ_NUM-1:0] pend,
    input  logic [IRQ_NUM-1:0] enab,
    input  logic [HOST_W-1:0]  host,
    output logic               take,
    output logic [1:0]         code
);

    logic [IRQ_NUM-1:0] live;
    logic               host_live;
    logic               m_open;
    logic               s_open;

    assign live      = pend & enab;
    assign host_live = |host;

    // machine group: below machine, or machine with enable set
    assign m_open = (cur_prv < 2'(PL_MACH)) ||
                    ((cur_prv == 2'(PL_MACH)) && cur_ie);
    // supervisor group: below supervisor, or supervisor with enable set
    assign s_open = (cur_prv < 2'(PL_SUPER)) ||
                    ((cur_prv == 2'(PL_SUPER)) && cur_ie);

    always_comb begin
        take = 1'b0;
        code = CODE_SW;
        if (m_open && live[IRQ_M_SW]) begin
            take = 1'b1;
            code = CODE_SW;
        end else if (m_open && live[IRQ_M_TM]) begin
            take = 1'b1;
            code = CODE_TM;
        end else if (m_open && host_live) begin
            take = 1'b1;
            code = CODE_HOST;
        end else if (s_open && live[IRQ_S_SW]) begin
            take = 1'b1;
            code = CODE_SW;
        end else if (s_open && live[IRQ_S_TM]) begin
            take = 1'b1;
            code = CODE_TM;
        end
    end

endmodule

// File: rtl/ptc_stack.sv
module ptc_stack
    import ptc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  event_e  ev,
    input  pstack_t ld_val,
    output pstack_t cur
);

    pstack_t nxt;

    always_comb begin
        nxt = cur;
        unique case (ev)
            EV_TRAP: begin
                nxt.prv2 = cur.prv1;
                nxt.ie2  = cur.ie1;
                nxt.prv1 = cur.prv;
                nxt.ie1  = cur.ie;
                nxt.prv  = PL_MACH;
                nxt.ie   = 1'b0;
                nxt.mprv = 1'b0;
            end
            EV_RET: begin
                nxt.prv  = cur.prv1;
                nxt.ie   = cur.ie1;
                nxt.prv1 = cur.prv2;
                nxt.ie1  = cur.ie2;
                nxt.prv2 = PL_USER;
                nxt.ie2  = 1'b1;
            end
            EV_LOAD: begin
                if (priv_ok(ld_val.prv))  nxt.prv  = ld_val.prv;
                if (priv_ok(ld_val.prv1)) nxt.prv1 = ld_val.prv1;
                if (priv_ok(ld_val.prv2)) nxt.prv2 = ld_val.prv2;
                nxt.ie   = ld_val.ie;
                nxt.ie1  = ld_val.ie1;
                nxt.ie2  = ld_val.ie2;
                nxt.mprv = ld_val.mprv;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur.prv  <= PL_MACH;
            cur.ie   <= 1'b0;
            cur.prv1 <= PL_USER;
            cur.ie1  <= 1'b0;
            cur.prv2 <= PL_USER;
            cur.ie2  <= 1'b0;
            cur.mprv <= 1'b0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/ptc_fsm.sv
module ptc_fsm
    import ptc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              ECODE_W  = 4,
    parameter logic [XLEN-1:0] VEC_BASE = 'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req,
    input  logic [ECODE_W-1:0] exc_code,
    input  logic               irq_take,
    input  logic [1:0]         irq_code,
    input  logic               ret_req,
    input  logic               ld_req,
    input  logic [1:0]         cur_prv,
    output event_e             ev,
    output fsm_e               state,
    output logic [XLEN-1:0]    pc,
    output logic [XLEN-1:0]    cause
);

    localparam logic [XLEN-1:0] BOOT_PC = VEC_BASE + XLEN'(BOOT_OFS);

    fsm_e            nxt_state;
    logic [XLEN-1:0] nxt_cause;
    logic [XLEN-1:0] trap_pc;

    // event selection: exception > interrupt > return > load
    always_comb begin
        ev        = EV_NONE;
        nxt_cause = cause;
        if (exc_req) begin
            ev        = EV_TRAP;
            nxt_cause = XLEN'(exc_code);
        end else if (irq_take) begin
            ev        = EV_TRAP;
            nxt_cause = {1'b1, (XLEN-1)'(irq_code)};
        end else if (ret_req) begin
            ev = EV_RET;
        end else if (ld_req) begin
            ev = EV_LOAD;
        end
    end

    always_comb begin
        unique case (ev)
            EV_TRAP: nxt_state = ST_ENTRY;
            EV_RET:  nxt_state = ST_EXIT;
            default: nxt_state = ST_IDLE;
        endcase
    end

    assign trap_pc = VEC_BASE + (XLEN'(cur_prv) << VEC_SHIFT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= nxt_state;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= BOOT_PC;
            cause <= '0;
        end else if (ev == EV_TRAP) begin
            pc    <= trap_pc;
            cause <= nxt_cause;
        end
    end

endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
    import ptc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              HOST_W   = 8,
    parameter int              ECODE_W  = 4,
    parameter logic [XLEN-1:0] VEC_BASE = 'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         irq_pend_i,
    input  logic [3:0]         irq_en_i,
    input  logic [HOST_W-1:0]  host_msg_i,
    input  logic               exc_req_i,
    input  logic [ECODE_W-1:0] exc_code_i,
    input  logic               ret_req_i,
    input  logic               st_ld_i,
    input  logic [1:0]         st_ld_prv_i,
    input  logic               st_ld_ie_i,
    input  logic [1:0]         st_ld_prv1_i,
    input  logic               st_ld_ie1_i,
    input  logic [1:0]         st_ld_prv2_i,
    input  logic               st_ld_ie2_i,
    input  logic               st_ld_mprv_i,
    output logic [1:0]         prv_o,
    output logic               ie_o,
    output logic [1:0]         prv1_o,
    output logic               ie1_o,
    output logic [1:0]         prv2_o,
    output logic               ie2_o,
    output logic               mprv_o,
    output logic [XLEN-1:0]    cause_o,
    output logic               redirect_vld_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic               resv_clr_o,
    output logic               ret_done_o
);

    pstack_t    stk;
    pstack_t    ld_val;
    event_e     ev;
    fsm_e       state;
    logic       irq_take;
    logic [1:0] irq_code;

    assign ld_val = '{prv:  st_ld_prv_i,  ie:  st_ld_ie_i,
                      prv1: st_ld_prv1_i, ie1: st_ld_ie1_i,
                      prv2: st_ld_prv2_i, ie2: st_ld_ie2_i,
                      mprv: st_ld_mprv_i};

    ptc_irq_arb #(.HOST_W(HOST_W)) u_arb (
        .cur_prv (stk.prv),
        .cur_ie  (stk.ie),
        .pend    (irq_pend_i),
        .enab    (irq_en_i),
        .host    (host_msg_i),
        .take    (irq_take),
        .code    (irq_code)
    );

    ptc_fsm #(.XLEN(XLEN), .ECODE_W(ECODE_W), .VEC_BASE(VEC_BASE)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .exc_req  (exc_req_i),
        .exc_code (exc_code_i),
        .irq_take (irq_take),
        .irq_code (irq_code),
        .ret_req  (ret_req_i),
        .ld_req   (st_ld_i),
        .cur_prv  (stk.prv),
        .ev       (ev),
        .state    (state),
        .pc       (redirect_pc_o),
        .cause    (cause_o)
    );

    ptc_stack u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .ld_val (ld_val),
        .cur    (stk)
    );

    assign prv_o  = stk.prv;
    assign ie_o   = stk.ie;
    assign prv1_o = stk.prv1;
    assign ie1_o  = stk.ie1;
    assign prv2_o = stk.prv2;
    assign ie2_o  = stk.ie2;
    assign mprv_o = stk.mprv;

    always_comb begin
        redirect_vld_o = 1'b0;
        resv_clr_o     = 1'b0;
        ret_done_o     = 1'b0;
        unique case (state)
            ST_BOOT:  redirect_vld_o = 1'b1;
            ST_ENTRY: begin
                redirect_vld_o = 1'b1;
                resv_clr_o     = 1'b1;
            end
            ST_EXIT:  ret_done_o = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/ptc_chk.sv
module ptc_chk #(
    parameter int              XLEN     = 32,
    parameter int              ECODE_W  = 4,
    parameter logic [XLEN-1:0] VEC_BASE = 'h100
) (
    input logic               clk,
    input logic               rst_n,
    input logic               exc_req_i,
    input logic [ECODE_W-1:0] exc_code_i,
    input logic [1:0]         prv_o,
    input logic               ie_o,
    input logic [1:0]         prv1_o,
    input logic               ie1_o,
    input logic [1:0]         prv2_o,
    input logic               ie2_o,
    input logic               mprv_o,
    input logic [XLEN-1:0]    cause_o,
    input logic [XLEN-1:0]    redirect_pc_o,
    input logic               resv_clr_o,
    input logic               ret_done_o
);

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clr_o |-> (prv_o == 2'd3) && !ie_o && !mprv_o); // R2

    AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clr_o |-> (prv1_o == $past(prv_o)) && (ie1_o == $past(ie_o)) &&
                       (prv2_o == $past(prv1_o)) && (ie2_o == $past(ie1_o))); // R2

    AST_POP_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done_o |-> (prv2_o == 2'd0) && ie2_o &&
                       (prv_o == $past(prv1_o)) && (ie_o == $past(ie1_o))); // R3

    AST_VEC_PC: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clr_o |-> redirect_pc_o == VEC_BASE + (XLEN'($past(prv_o)) << 6)); // R4

    AST_M_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((prv_o == 2'd3) && !ie_o && !exc_req_i) |=> !resv_clr_o); // R5

    AST_INT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_clr_o && cause_o[XLEN-1]) |-> cause_o[XLEN-2:0] <= (XLEN-1)'(2)); // R8

    AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req_i |=> resv_clr_o && !cause_o[XLEN-1] &&
                      (cause_o[ECODE_W-1:0] == $past(exc_code_i))); // R9

    AST_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (prv_o != 2'd2) && (prv1_o != 2'd2) && (prv2_o != 2'd2)); // R10

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resv_clr_o, ret_done_o})); // R11

endmodule

bind priv_trap_unit ptc_chk #(
    .XLEN(XLEN), .ECODE_W(ECODE_W), .VEC_BASE(VEC_BASE)
) u_ptc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_req_i     (exc_req_i),
    .exc_code_i    (exc_code_i),
    .prv_o         (prv_o),
    .ie_o          (ie_o),
    .prv1_o        (prv1_o),
    .ie1_o         (ie1_o),
    .prv2_o        (prv2_o),
    .ie2_o         (ie2_o),
    .mprv_o        (mprv_o),
    .cause_o       (cause_o),
    .redirect_pc_o (redirect_pc_o),
    .resv_clr_o    (resv_clr_o),
    .ret_done_o    (ret_done_o)
);

// File: tb/tb_priv_trap_unit.sv
`timescale 1ns/1ps
module tb_priv_trap_unit;

    localparam int          XLEN     = 32;
    localparam int          HOST_W   = 8;
    localparam int          ECODE_W  = 4;
    localparam logic [31:0] VEC_BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_pend, irq_en;
    logic [7:0]  host_msg;
    logic        exc_req, ret_req, st_ld;
    logic [3:0]  exc_code;
    logic [1:0]  l_prv, l_prv1, l_prv2;
    logic        l_ie, l_ie1, l_ie2, l_mprv;
    logic [1:0]  prv_o, prv1_o, prv2_o;
    logic        ie_o, ie1_o, ie2_o, mprv_o;
    logic [31:0] cause_o, redirect_pc_o;
    logic        redirect_vld_o, resv_clr_o, ret_done_o;

    priv_trap_unit #(.XLEN(XLEN), .HOST_W(HOST_W), .ECODE_W(ECODE_W), .VEC_BASE(VEC_BASE)) dut (
        .clk(clk), .rst_n(rst_n), .irq_pend_i(irq_pend), .irq_en_i(irq_en),
        .host_msg_i(host_msg), .exc_req_i(exc_req), .exc_code_i(exc_code),
        .ret_req_i(ret_req), .st_ld_i(st_ld), .st_ld_prv_i(l_prv), .st_ld_ie_i(l_ie),
        .st_ld_prv1_i(l_prv1), .st_ld_ie1_i(l_ie1), .st_ld_prv2_i(l_prv2),
        .st_ld_ie2_i(l_ie2), .st_ld_mprv_i(l_mprv),
        .prv_o(prv_o), .ie_o(ie_o), .prv1_o(prv1_o), .ie1_o(ie1_o), .prv2_o(prv2_o),
        .ie2_o(ie2_o), .mprv_o(mprv_o), .cause_o(cause_o), .redirect_vld_o(redirect_vld_o),
        .redirect_pc_o(redirect_pc_o), .resv_clr_o(resv_clr_o), .ret_done_o(ret_done_o)
    );

    always #2.5 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state (expected outputs after the last edge)
    logic [1:0]  m_prv, m_prv1, m_prv2;
    logic        m_ie, m_ie1, m_ie2, m_mprv;
    logic [31:0] m_cause, m_pc;
    logic        m_rv, m_clr, m_rd;

    task automatic chk(string lab, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", lab, what, act, exp);
        end
    endtask

    task automatic check_all(string lab, string st);
        chk(lab, {st, " prv"},  32'(prv_o),  32'(m_prv));
        chk(lab, {st, " ie"},   32'(ie_o),   32'(m_ie));
        chk(lab, {st, " prv1"}, 32'(prv1_o), 32'(m_prv1));
        chk(lab, {st, " ie1"},  32'(ie1_o),  32'(m_ie1));
        chk(lab, {st, " prv2"}, 32'(prv2_o), 32'(m_prv2));
        chk(lab, {st, " ie2"},  32'(ie2_o),  32'(m_ie2));
        chk(lab, {st, " mprv"}, 32'(mprv_o), 32'(m_mprv));
        chk(lab, "R4 redirect valid", 32'(redirect_vld_o), 32'(m_rv));
        chk(lab, "R4 redirect pc", redirect_pc_o, m_pc);
        chk(lab, "R4 resv clear", 32'(resv_clr_o), 32'(m_clr));
        chk(lab, "R3 ret done", 32'(ret_done_o), 32'(m_rd));
        chk(lab, "R8 cause", cause_o, m_cause);
    endtask

    // {take, code} from R5/R6/R7
    function automatic logic [2:0] m_irq(logic [1:0] p, logic e, logic [3:0] pd,
                                         logic [3:0] en, logic [7:0] h);
        logic mo, so;
        logic [3:0] lv;
        mo = (p < 2'd3) || (p == 2'd3 && e);
        so = (p < 2'd1) || (p == 2'd1 && e);
        lv = pd & en;
        if (mo && lv[1]) return 3'b100;
        if (mo && lv[3]) return 3'b101;
        if (mo && h != 8'd0) return 3'b110;
        if (so && lv[0]) return 3'b100;
        if (so && lv[2]) return 3'b101;
        return 3'b000;
    endfunction

    task automatic m_trap(logic [31:0] c);
        m_pc   = VEC_BASE + 32'(m_prv) * 32'h40;
        m_prv2 = m_prv1; m_ie2 = m_ie1;
        m_prv1 = m_prv;  m_ie1 = m_ie;
        m_prv  = 2'd3;   m_ie  = 1'b0; m_mprv = 1'b0;
        m_cause = c;
        m_rv = 1'b1; m_clr = 1'b1; m_rd = 1'b0;
    endtask

    task automatic model_reset();
        m_prv = 2'd3; m_prv1 = 2'd0; m_prv2 = 2'd0;
        m_ie = 0; m_ie1 = 0; m_ie2 = 0; m_mprv = 0;
        m_cause = 32'd0; m_pc = VEC_BASE + 32'h100;
        m_rv = 1'b1; m_clr = 1'b0; m_rd = 1'b0;
    endtask

    // called at a negedge with inputs already driven
    task automatic step(string lab);
        logic [2:0] ir;
        string st;
        ir = m_irq(m_prv, m_ie, irq_pend, irq_en, host_msg);
        m_rv = 1'b0; m_clr = 1'b0; m_rd = 1'b0;
        if (exc_req) begin
            m_trap(32'(exc_code)); st = "R2";
        end else if (ir[2]) begin
            m_trap({1'b1, 29'd0, ir[1:0]}); st = "R2";
        end else if (ret_req) begin
            m_prv = m_prv1; m_ie = m_ie1;
            m_prv1 = m_prv2; m_ie1 = m_ie2;
            m_prv2 = 2'd0; m_ie2 = 1'b1;
            m_rd = 1'b1; st = "R3";
        end else if (st_ld) begin
            if (l_prv  != 2'd2) m_prv  = l_prv;
            if (l_prv1 != 2'd2) m_prv1 = l_prv1;
            if (l_prv2 != 2'd2) m_prv2 = l_prv2;
            m_ie = l_ie; m_ie1 = l_ie1; m_ie2 = l_ie2; m_mprv = l_mprv;
            st = "R10";
        end else begin
            st = "R11";
        end
        @(negedge clk);
        check_all(lab, st);
    endtask

    task automatic clr_in();
        irq_pend = 0; irq_en = 0; host_msg = 0; exc_req = 0; exc_code = 0;
        ret_req = 0; st_ld = 0; l_prv = 0; l_ie = 0; l_prv1 = 0; l_ie1 = 0;
        l_prv2 = 0; l_ie2 = 0; l_mprv = 0;
    endtask

    task automatic load(logic [1:0] p, logic e, logic [1:0] p1, logic e1,
                        logic [1:0] p2, logic e2, logic mp, string lab);
        clr_in();
        st_ld = 1; l_prv = p; l_ie = e; l_prv1 = p1; l_ie1 = e1;
        l_prv2 = p2; l_ie2 = e2; l_mprv = mp;
        step(lab);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL R11 watchdog: got %h expected %h", 32'd0, 32'd1);
            finish_run();
        end
    end

    int seed_dummy;

    initial begin
        clr_in();
        model_reset();
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset", "R1");
        rst_n = 1'b1;
        clr_in();
        step("R11 idle after reset");

        // R10: reserved privilege refused per field, others written
        load(2'd2, 1'b1, 2'd1, 1'b1, 2'd2, 1'b0, 1'b1, "R10 reserved priv");
        chk("R10", "prv kept machine", 32'(prv_o), 32'd3);

        // R5: machine open with enable set, then closed after the push
        clr_in(); irq_pend = 4'b1000; irq_en = 4'b1000;
        step("R5 machine open");
        chk("R5", "timer cause", cause_o, 32'h8000_0001);
        clr_in(); irq_pend = 4'b0010; irq_en = 4'b0010;
        step("R5 machine closed");
        chk("R5", "masked no trap", 32'(resv_clr_o), 32'd0);

        // R3: returns
        clr_in(); ret_req = 1; step("R3 pop one");
        clr_in(); ret_req = 1; step("R3 pop two");
        chk("R3", "refill ie2", 32'(ie2_o), 32'd1);

        // R6: supervisor gate
        load(2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R6 load super");
        clr_in(); irq_pend = 4'b0001; irq_en = 4'b0001;
        step("R6 super closed");
        chk("R6", "no trap", 32'(resv_clr_o), 32'd0);
        load(2'd1, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R6 load super ie");
        clr_in(); irq_pend = 4'b0001; irq_en = 4'b0001;
        step("R6 super open");
        chk("R6", "soft cause", cause_o, 32'h8000_0000);
        chk("R4", "vector from super", redirect_pc_o, VEC_BASE + 32'h40);

        // R7: priority ladder from user
        load(2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R7 to user");
        clr_in(); irq_pend = 4'hF; irq_en = 4'hF; host_msg = 8'h05;
        step("R7 all live");
        chk("R7", "machine soft first", cause_o, 32'h8000_0000);
        chk("R4", "vector from user", redirect_pc_o, VEC_BASE);
        load(2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R7 to user");
        clr_in(); irq_pend = 4'b1101; irq_en = 4'hF; host_msg = 8'h05;
        step("R7 timer over host");
        chk("R7", "machine timer", cause_o, 32'h8000_0001);
        load(2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R7 to user");
        clr_in(); irq_pend = 4'b0101; irq_en = 4'hF; host_msg = 8'h80;
        step("R7 host over super");
        chk("R7", "host code", cause_o, 32'h8000_0002);
        load(2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R7 to user");
        clr_in(); irq_pend = 4'hF; irq_en = 4'b0100;
        step("R7 enable mask");
        chk("R7", "super timer only", cause_o, 32'h8000_0001);

        // R9: coincident events
        load(2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R9 to user");
        clr_in(); irq_pend = 4'hF; irq_en = 4'hF; exc_req = 1; exc_code = 4'hB;
        step("R9 exception beats interrupt");
        chk("R9", "exception cause", cause_o, 32'h0000_000B);
        load(2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, "R9 to user");
        clr_in(); irq_pend = 4'b0010; irq_en = 4'b0010; ret_req = 1;
        step("R9 interrupt beats return");
        chk("R9", "no ret done", 32'(ret_done_o), 32'd0);
        clr_in(); ret_req = 1; st_ld = 1; l_prv = 2'd1; l_mprv = 1;
        step("R9 return beats load");
        chk("R9", "ret done", 32'(ret_done_o), 32'd1);
        clr_in(); step("R11 quiet");

        // constrained random phase
        for (int i = 0; i < 3000; i++) begin
            clr_in();
            irq_pend = 4'($urandom);
            irq_en   = 4'($urandom);
            host_msg = (($urandom % 8) == 0) ? 8'(($urandom % 255) + 1) : 8'd0;
            exc_req  = (($urandom % 7) == 0);
            exc_code = 4'($urandom);
            ret_req  = (($urandom % 4) == 0);
            st_ld    = (($urandom % 4) == 0);
            l_prv = 2'($urandom); l_prv1 = 2'($urandom); l_prv2 = 2'($urandom);
            l_ie = 1'($urandom); l_ie1 = 1'($urandom); l_ie2 = 1'($urandom);
            l_mprv = 1'($urandom);
            step("random");
        end

        finish_run();
    end

endmodule